// File: doc/BRIEF.md
# Shadow-Stack-Aware Page Permission Checker

This block decides whether one memory access may go ahead, given the permission bits of the leaf page-table entry that maps it. When the access is refused, the block names the fault. It covers ordinary loads, stores and instruction fetches. It also covers shadow-stack loads and stores, and probe-style store checks of the kind that cache-block clean, flush and invalidate operations issue. One entry encoding that is otherwise reserved (write set, read and execute clear) is taken as a shadow-stack page, but only when backward control-flow protection is on and the lookup is first-stage. Faults that arise on such pages are reported as access faults, not page faults.

The requester raises `req_i` for one cycle with the entry bits and the access attributes. One cycle later the block shows the verdict, the effective read/write/execute set and a 5-bit cause code, together with a single-cycle `rsp_valid_o`. A two-state controller sequences this. `ST_IDLE` moves to `ST_RESP` on a request and otherwise stays put. `ST_RESP` stays in `ST_RESP` when another request arrives in the same cycle, which allows back-to-back requests, and otherwise returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `sspc_checker`

## Requirements
- R1: A request sampled on a rising edge produces `rsp_valid_o` high in the next cycle. `rsp_valid_o` is never high unless a request was sampled on the previous edge. A synchronous active-high reset clears `rsp_valid_o`.
- R2: Alignment is checked before permissions. `acc_size_i` values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and an access is misaligned when `addr_lo_i` is not a multiple of the size. For a misaligned regular access the cause is 4 for a load (`acc_kind_i`=0), 6 for a store (`acc_kind_i`=1) and 0 for a fetch (`acc_kind_i`=2).
- R3: A misaligned shadow-stack access (`ss_acc_i`=1) gives cause 5 when it is a load and cause 7 otherwise.
- R4: An entry with V=0 is refused with a page fault and effective set 000. The cause is 13 for a load, 15 for a store and 12 for a fetch, and always 15 for a shadow-stack access.
- R5: The encoding W=1, X=1, R=0 is always refused as a page fault, with effective set 000.
- R6: The encoding W=1, R=0, X=0 is refused as a page fault with effective set 000 unless `bcfi_en_i` and `first_stage_i` are both 1.
- R7: On a shadow-stack page the effective set (`rsp_rwx_o` bit0=R, bit1=W, bit2=X) is 011 for a shadow-stack access, 001 for a regular access that is not a probe, and 000 for a probe.
- R8: When the effective set refuses an access on a shadow-stack page, an access fault is reported. The cause is 5 for a load, 7 for a store and 1 for a fetch, and always 7 for a shadow-stack access. A probe store on such a page therefore always gets 7.
- R9: A shadow-stack access to an entry with R=1, W=0, X=0 is refused with cause 15, whatever the access kind, and with effective set 000.
- R10: Any other valid entry has effective set {X,W,R}. A refused access gets the page-fault cause of R4. A granted access sets `rsp_ok_o` and gives cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; inputs sampled on this edge |
| pte_v_i | input | 1 | Entry valid bit |
| pte_r_i | input | 1 | Entry read bit |
| pte_w_i | input | 1 | Entry write bit |
| pte_x_i | input | 1 | Entry execute bit |
| acc_kind_i | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| ss_acc_i | input | 1 | Access is a shadow-stack access |
| probe_i | input | 1 | Access is a probe (cache-block operation check) |
| bcfi_en_i | input | 1 | Backward control-flow protection enabled |
| first_stage_i | input | 1 | Lookup is first-stage translation |
| acc_size_i | input | 2 | log2 of the access size in bytes |
| addr_lo_i | input | 3 | Low address bits |
| rsp_valid_o | output | 1 | One-cycle pulse marking a result |
| rsp_ok_o | output | 1 | Access granted |
| rsp_rwx_o | output | 3 | Effective permissions {X,W,R} |
| rsp_cause_o | output | 5 | Exception cause; 0 when granted |

## Verification
The assertions assume that request inputs are stable and known on the sampling edge, and that `rsp_*` is judged only while `rsp_valid_o` is high. They also assume that a reserved or read-only-to-shadow-stack entry is refused no matter how alignment turns out. The stimulus changes inputs only on the falling clock edge, holds `req_i` low throughout reset, and draws the access kind only from load, store and fetch. Random draws cover every entry encoding and every flag combination. Directed cases cover the shadow-stack page, probe, misalignment and reserved-encoding corners.

// File: rtl/sspc_pkg.sv
package sspc_pkg;

    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_MISALIGN = 2'd1,
        FC_ACCESS   = 2'd2,
        FC_PAGE     = 2'd3
    } fault_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

    localparam logic [CAUSE_W-1:0] CC_FETCH_MIS = 5'd0;
    localparam logic [CAUSE_W-1:0] CC_FETCH_ACC = 5'd1;
    localparam logic [CAUSE_W-1:0] CC_LOAD_MIS  = 5'd4;
    localparam logic [CAUSE_W-1:0] CC_LOAD_ACC  = 5'd5;
    localparam logic [CAUSE_W-1:0] CC_STORE_MIS = 5'd6;
    localparam logic [CAUSE_W-1:0] CC_STORE_ACC = 5'd7;
    localparam logic [CAUSE_W-1:0] CC_FETCH_PG  = 5'd12;
    localparam logic [CAUSE_W-1:0] CC_LOAD_PG   = 5'd13;
    localparam logic [CAUSE_W-1:0] CC_STORE_PG  = 5'd15;
    localparam logic [CAUSE_W-1:0] CC_NONE      = 5'd0;

endpackage

// File: rtl/sspc_align.sv
module sspc_align #(
    parameter int SIZE_W = 2,
    localparam int OFF_W = (1 << SIZE_W) - 1
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic              misaligned_o
);

    logic [OFF_W-1:0] mask;

    // offset bit i must be zero whenever the access spans more than 2**i bytes
    for (genvar i = 0; i < OFF_W; i++) begin : g_mask
        assign mask[i] = (size_i > SIZE_W'(i));
    end

    assign misaligned_o = |(off_i & mask);

endmodule

// File: rtl/sspc_perm.sv
module sspc_perm
    import sspc_pkg::*;
(
    input  logic          v_i,
    input  logic          r_i,
    input  logic          w_i,
    input  logic          x_i,
    input  acc_kind_e     kind_i,
    input  logic          ss_i,
    input  logic          probe_i,
    input  logic          bcfi_i,
    input  logic          first_i,
    output logic [2:0]    eff_o,
    output fault_class_e  fclass_o
);

    logic       page_flt;
    logic       ss_page;
    logic       wanted;

    always_comb begin
        eff_o    = 3'b000;
        page_flt = 1'b0;
        ss_page  = 1'b0;
        if (!v_i) begin
            page_flt = 1'b1;
        end else begin
            case ({x_i, w_i, r_i})
                3'b110: page_flt = 1'b1;
                3'b010: begin
                    if (bcfi_i && first_i) begin
                        ss_page = 1'b1;
                        if (ss_i)         eff_o = 3'b011;
                        else if (probe_i) eff_o = 3'b000;
                        else              eff_o = 3'b001;
                    end else begin
                        page_flt = 1'b1;
                    end
                end
                3'b001: begin
                    if (ss_i) page_flt = 1'b1;
                    else      eff_o = 3'b001;
                end
                default: eff_o = {x_i, w_i, r_i};
            endcase
        end
    end

    always_comb begin
        unique case (kind_i)
            ACC_LOAD:  wanted = eff_o[0];
            ACC_STORE: wanted = eff_o[1];
            default:   wanted = eff_o[2];
        endcase
    end

    always_comb begin
        if (page_flt)            fclass_o = FC_PAGE;
        else if (wanted)         fclass_o = FC_NONE;
        else if (ss_page)        fclass_o = FC_ACCESS;
        else                     fclass_o = FC_PAGE;
    end

endmodule

// File: rtl/sspc_cause.sv
module sspc_cause
    import sspc_pkg::*;
(
    input  fault_class_e        fclass_i,
    input  acc_kind_e           kind_i,
    input  logic                ss_i,
    output logic [CAUSE_W-1:0]  cause_o
);

    always_comb begin
        cause_o = CC_NONE;
        unique case (fclass_i)
            FC_NONE: cause_o = CC_NONE;
            FC_MISALIGN: begin
                if (ss_i)                    cause_o = (kind_i == ACC_LOAD) ? CC_LOAD_ACC : CC_STORE_ACC;
                else if (kind_i == ACC_LOAD)  cause_o = CC_LOAD_MIS;
                else if (kind_i == ACC_STORE) cause_o = CC_STORE_MIS;
                else                          cause_o = CC_FETCH_MIS;
            end
            FC_ACCESS: begin
                if (ss_i)                    cause_o = CC_STORE_ACC;
                else if (kind_i == ACC_LOAD)  cause_o = CC_LOAD_ACC;
                else if (kind_i == ACC_STORE) cause_o = CC_STORE_ACC;
                else                          cause_o = CC_FETCH_ACC;
            end
            FC_PAGE: begin
                if (ss_i)                    cause_o = CC_STORE_PG;
                else if (kind_i == ACC_LOAD)  cause_o = CC_LOAD_PG;
                else if (kind_i == ACC_STORE) cause_o = CC_STORE_PG;
                else                          cause_o = CC_FETCH_PG;
            end
        endcase
    end

endmodule

// File: rtl/sspc_checker.sv
module sspc_checker
    import sspc_pkg::*;
#(
    parameter int SIZE_W = 2,
    localparam int OFF_W = (1 << SIZE_W) - 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_i,
    input  logic               pte_v_i,
    input  logic               pte_r_i,
    input  logic               pte_w_i,
    input  logic               pte_x_i,
    input  logic [1:0]         acc_kind_i,
    input  logic               ss_acc_i,
    input  logic               probe_i,
    input  logic               bcfi_en_i,
    input  logic               first_stage_i,
    input  logic [SIZE_W-1:0]  acc_size_i,
    input  logic [OFF_W-1:0]   addr_lo_i,
    output logic               rsp_valid_o,
    output logic               rsp_ok_o,
    output logic [2:0]         rsp_rwx_o,
    output logic [CAUSE_W-1:0] rsp_cause_o
);

    acc_kind_e          kind;
    logic               misaligned;
    logic [2:0]         eff;
    fault_class_e       perm_class;
    fault_class_e       final_class;
    logic [CAUSE_W-1:0] cause;
    ctl_state_e         state_q, state_d;

    assign kind = acc_kind_e'(acc_kind_i);

    sspc_align #(.SIZE_W(SIZE_W)) u_align (
        .size_i       (acc_size_i),
        .off_i        (addr_lo_i),
        .misaligned_o (misaligned)
    );

    sspc_perm u_perm (
        .v_i      (pte_v_i),
        .r_i      (pte_r_i),
        .w_i      (pte_w_i),
        .x_i      (pte_x_i),
        .kind_i   (kind),
        .ss_i     (ss_acc_i),
        .probe_i  (probe_i),
        .bcfi_i   (bcfi_en_i),
        .first_i  (first_stage_i),
        .eff_o    (eff),
        .fclass_o (perm_class)
    );

    // alignment outranks any permission verdict
    assign final_class = misaligned ? FC_MISALIGN : perm_class;

    sspc_cause u_cause (
        .fclass_i (final_class),
        .kind_i   (kind),
        .ss_i     (ss_acc_i),
        .cause_o  (cause)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_i ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_ok_o    <= 1'b0;
            rsp_rwx_o   <= 3'b000;
            rsp_cause_o <= CC_NONE;
        end else if (req_i) begin
            rsp_ok_o    <= (final_class == FC_NONE);
            rsp_rwx_o   <= eff;
            rsp_cause_o <= cause;
        end
    end

    assign rsp_valid_o = (state_q == ST_RESP);

    // R1
    valid_needs_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_valid_o |-> $past(req_i));

    // R1
    req_gives_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> rsp_valid_o);

    // R5
    wx_reserved_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_valid_o && $past(pte_w_i && pte_x_i && !pte_r_i) |-> !rsp_ok_o && (rsp_rwx_o == 3'b000));

    // R7
    ss_probe_none_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_valid_o && $past(pte_v_i && pte_w_i && !pte_r_i && !pte_x_i && bcfi_en_i
                             && first_stage_i && probe_i && !ss_acc_i)
        |-> !rsp_ok_o && (rsp_rwx_o == 3'b000));

    // R9
    ss_readonly_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_valid_o && $past(pte_v_i && pte_r_i && !pte_w_i && !pte_x_i && ss_acc_i)
        |-> !rsp_ok_o && (rsp_cause_o == 5'd15 || rsp_cause_o == 5'd5 || rsp_cause_o == 5'd7));

    // R10
    ok_zero_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rsp_valid_o && rsp_ok_o |-> rsp_cause_o == 5'd0);

endmodule

// File: tb/sspc_checker_bench.sv
module sspc_checker_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       req, v, r, w, x, ss, probe, bcfi, first;
    logic [1:0] kind, size;
    logic [2:0] off;
    logic       rsp_valid, rsp_ok;
    logic [2:0] rsp_rwx;
    logic [4:0] rsp_cause;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sspc_checker u_sspc_checker (
        .clk_i (clk), .rst_i (rst), .req_i (req),
        .pte_v_i (v), .pte_r_i (r), .pte_w_i (w), .pte_x_i (x),
        .acc_kind_i (kind), .ss_acc_i (ss), .probe_i (probe),
        .bcfi_en_i (bcfi), .first_stage_i (first),
        .acc_size_i (size), .addr_lo_i (off),
        .rsp_valid_o (rsp_valid), .rsp_ok_o (rsp_ok),
        .rsp_rwx_o (rsp_rwx), .rsp_cause_o (rsp_cause)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // expected {ok, rwx[2:0], cause[4:0]} from the requirements
    function automatic logic [8:0] model(logic mv, logic mr, logic mw, logic mx, logic [1:0] mk,
                                         logic mss, logic mpr, logic mb, logic mf,
                                         logic [1:0] msz, logic [2:0] mo);
        logic [2:0] e; logic pg, ssp, mis, want, ok; logic [4:0] c;
        int bytes;
        bytes = 1 << msz;
        mis = (int'(mo) % bytes) != 0;
        e = 3'b000; pg = 1'b0; ssp = 1'b0; ok = 1'b0;
        if (!mv) pg = 1'b1;
        else if (mw && mx && !mr) pg = 1'b1;
        else if (mw && !mr && !mx) begin
            if (mb && mf) begin ssp = 1'b1; e = mss ? 3'b011 : (mpr ? 3'b000 : 3'b001); end
            else pg = 1'b1;
        end
        else if (mr && !mw && !mx && mss) pg = 1'b1;
        else e = {mx, mw, mr};
        want = (mk == 2'd0) ? e[0] : (mk == 2'd1) ? e[1] : e[2];
        if (mis)
            c = mss ? ((mk == 2'd0) ? 5'd5 : 5'd7) : ((mk == 2'd0) ? 5'd4 : (mk == 2'd1) ? 5'd6 : 5'd0);
        else if (pg || (!want && !ssp))
            c = mss ? 5'd15 : ((mk == 2'd0) ? 5'd13 : (mk == 2'd1) ? 5'd15 : 5'd12);
        else if (!want)
            c = mss ? 5'd7 : ((mk == 2'd0) ? 5'd5 : (mk == 2'd1) ? 5'd7 : 5'd1);
        else begin ok = 1'b1; c = 5'd0; end
        return {ok, e, c};
    endfunction

    task automatic run(string tag, logic tv, logic tr, logic tw, logic tx, logic [1:0] tk,
                       logic tss, logic tpr, logic tb, logic tf, logic [1:0] tsz,
                       logic [2:0] to, logic [8:0] exp);
        @(negedge clk);
        v = tv; r = tr; w = tw; x = tx; kind = tk; ss = tss; probe = tpr;
        bcfi = tb; first = tf; size = tsz; off = to; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check(tag, 32'({rsp_ok, rsp_rwx, rsp_cause}), 32'(exp));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; req = 1'b0; v = 1'b0; r = 1'b0; w = 1'b0; x = 1'b0;
        kind = 2'd0; ss = 1'b0; probe = 1'b0; bcfi = 1'b0; first = 1'b0;
        size = 2'd0; off = 3'd0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        rst = 1'b0;

        // shadow-stack page: ss store granted with RW (R7)
        run("R7 ss store", 1,0,1,0, 2'd1, 1,0,1,1, 2'd3, 3'd0, {1'b1, 3'b011, 5'd0});
        @(negedge clk);
        check("R1 single pulse", 32'(rsp_valid), 32'd0);
        run("R7 regular load", 1,0,1,0, 2'd0, 0,0,1,1, 2'd2, 3'd4, {1'b1, 3'b001, 5'd0});
        run("R8 regular store", 1,0,1,0, 2'd1, 0,0,1,1, 2'd0, 3'd3, {1'b0, 3'b001, 5'd7});
        run("R8 probe store", 1,0,1,0, 2'd1, 0,1,1,1, 2'd3, 3'd0, {1'b0, 3'b000, 5'd7});
        run("R8 probe load", 1,0,1,0, 2'd0, 0,1,1,1, 2'd0, 3'd0, {1'b0, 3'b000, 5'd5});
        run("R8 fetch ss page", 1,0,1,0, 2'd2, 0,0,1,1, 2'd2, 3'd0, {1'b0, 3'b001, 5'd1});
        run("R6 no bcfi store", 1,0,1,0, 2'd1, 1,0,0,1, 2'd0, 3'd0, {1'b0, 3'b000, 5'd15});
        run("R6 second stage load", 1,0,1,0, 2'd0, 0,0,1,0, 2'd0, 3'd0, {1'b0, 3'b000, 5'd13});
        run("R9 ss load readonly", 1,1,0,0, 2'd0, 1,0,1,1, 2'd3, 3'd0, {1'b0, 3'b000, 5'd15});
        run("R5 wx load", 1,0,1,1, 2'd0, 0,0,1,1, 2'd0, 3'd0, {1'b0, 3'b000, 5'd13});
        run("R4 invalid fetch", 0,1,1,1, 2'd2, 0,0,0,0, 2'd2, 3'd0, {1'b0, 3'b000, 5'd12});
        run("R4 invalid ss load", 0,1,1,0, 2'd0, 1,0,1,1, 2'd0, 3'd0, {1'b0, 3'b000, 5'd15});
        run("R3 ss load misaligned", 1,0,1,0, 2'd0, 1,0,1,1, 2'd3, 3'd4, {1'b0, 3'b011, 5'd5});
        run("R3 ss store misaligned", 1,0,1,0, 2'd1, 1,0,1,1, 2'd2, 3'd2, {1'b0, 3'b011, 5'd7});
        run("R2 half misaligned", 1,1,1,0, 2'd0, 0,0,0,0, 2'd1, 3'd1, {1'b0, 3'b011, 5'd4});
        run("R2 store misaligned", 1,1,1,0, 2'd1, 0,0,0,0, 2'd3, 3'd2, {1'b0, 3'b011, 5'd6});
        run("R2 fetch misaligned", 1,0,0,1, 2'd2, 0,0,0,0, 2'd2, 3'd2, {1'b0, 3'b100, 5'd0});
        run("R10 rx fetch", 1,1,0,1, 2'd2, 0,0,0,0, 2'd2, 3'd4, {1'b1, 3'b101, 5'd0});
        run("R10 readonly store", 1,1,0,0, 2'd1, 0,0,0,0, 2'd0, 3'd7, {1'b0, 3'b001, 5'd15});

        // back-to-back requests keep valid high (R1)
        @(negedge clk);
        v = 1; r = 1; w = 1; x = 0; kind = 2'd0; ss = 0; probe = 0; size = 2'd0; off = 3'd0;
        req = 1'b1;
        @(negedge clk);
        check("R1 b2b first", 32'(rsp_valid), 32'd1);
        kind = 2'd2;
        @(negedge clk);
        req = 1'b0;
        check("R1 b2b second", 32'({rsp_valid, rsp_ok, rsp_cause}), 32'({1'b1, 1'b0, 5'd12}));

        for (int i = 0; i < 600; i++) begin
            logic [2:0] rv_off; logic [1:0] rv_k, rv_s; logic rv_v, rv_r, rv_w, rv_x, rv_ss, rv_p, rv_b, rv_f;
            rv_v = ($urandom % 8) != 0;
            rv_r = 1'($urandom); rv_w = 1'($urandom); rv_x = 1'($urandom);
            rv_k = 2'($urandom % 3);
            rv_ss = 1'($urandom); rv_p = 1'($urandom);
            rv_b = 1'($urandom); rv_f = 1'($urandom);
            rv_s = 2'($urandom);
            rv_off = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom);
            run("R10 random", rv_v, rv_r, rv_w, rv_x, rv_k, rv_ss, rv_p, rv_b, rv_f, rv_s, rv_off,
                model(rv_v, rv_r, rv_w, rv_x, rv_k, rv_ss, rv_p, rv_b, rv_f, rv_s, rv_off));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule